// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt request to a processor. Software sets it up through a byte-wide register interface, where one address bit picks one of two ports. Setup is a short, ordered series of words. After setup, the controller latches requests, applies a mask, and resolves fixed priority.

The processor answers an interrupt with an acknowledge pulse. During that pulse the controller places a vector on its read data. The vector is a programmed base plus the number of the winning line. The acknowledged line is recorded as in service. While it stays in service, it holds off requests of equal or lower priority. An end-of-interrupt command written by software releases it.

A cascade byte is accepted during setup so that the write sequence stays correct, but nothing uses it.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, the mask is 0xFF, the in-service set is 0x00, and `int_req` is low.
- R2: A port 0 write with bit 4 set is the first setup word. It can arrive at any time, and it restarts setup. It also clears all pending and in-service bits and sets the mask to 0xFF. `int_req` stays low until setup completes.
- R3: The setup sequence runs as follows:
  - The next port 1 write after the first word is the second word. Its bits 7:3 become the vector base.
  - A third word is expected on port 1 only when bit 1 of the first word is 0.
  - A fourth word is expected only when bit 0 of the first word is 1.
  - After the last expected word, the next port 1 write is a mask write.
- R4: Once setup is complete, a port 1 write loads the mask. Reading port 1 returns the mask. A line whose mask bit is 1 cannot raise `int_req`.
- R5: Edge mode is selected when bit 3 of the first setup word is 0. In this mode a request latches on a rising edge of its line. It stays latched until it is acknowledged, even if the line stays high.
- R6: Level mode is selected when bit 3 of the first setup word is 1. In this mode the pending set follows the line levels one cycle late. A line that is still high raises `int_req` again once its in-service bit is cleared.
- R7: Line 0 has the highest priority and line 7 the lowest. An unmasked pending line raises `int_req` only if no line of equal or higher priority is in service.
- R8: While `inta` is high and `int_req` is high:
  - `rdata` equals {base[7:3], winning line number[2:0]}.
  - The winning line becomes in service on that clock edge.
- R9: A port 0 write is an end-of-interrupt command when bit 4 = 0, bit 3 = 0, bit 5 = 1 and bit 6 = 0. It clears the highest-priority in-service bit. A write with bit 6 = 1 leaves the in-service set unchanged.
- R10: While `inta` is low, reading port 0 returns the in-service set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Port select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Mask, in-service set, or vector during acknowledge |
| irq_in | input | 8 | Interrupt request lines |
| int_req | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |

## Verification
A corrupted setup state appears at once as a missing or wrong vector base, or as a mask write that never reads back. A wrong in-service set shows on the port 0 read in the cycle after the acknowledge or end-of-interrupt command. It also shows within one cycle as a lower-priority `int_req` that is wrongly held off or wrongly let through. Faults in edge detection show as a second vector for a single rising edge, or as no vector at all.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_req,
  input  logic       inta
);
  typedef enum logic [2:0] {S_UNINIT, S_W2, S_W3, S_W4, S_RDY} st_t;
  st_t        state;
  logic [7:0] irr, isr, mask, prev;
  logic [4:0] base;
  logic       ltim, sngl, ic4;
  logic [7:0] cascade;

  logic [7:0] pend;
  logic [2:0] win;
  logic [3:0] slev;
  logic       ready, icw1, port1, eoi, ack;
  logic [7:0] set_m, clr_m;

  assign ready = (state == S_RDY);
  assign pend  = irr & ~mask;
  assign icw1  = wr_en && !addr && wdata[4];
  assign port1 = wr_en && addr;
  assign eoi   = wr_en && !addr && !wdata[4] && !wdata[3] && wdata[5] && !wdata[6] && ready;

  always_comb begin
    win  = 3'd0;
    slev = 4'd8;
    for (int i = 7; i >= 0; i--) begin
      if (pend[i]) win = 3'(i);
      if (isr[i]) slev = 4'(i);
    end
  end

  assign int_req = ready && (pend != 8'h00) && ({1'b0, win} < slev);
  assign ack     = inta && int_req;
  assign set_m   = ack ? (8'h01 << win) : 8'h00;
  assign clr_m   = eoi ? (isr & (~isr + 8'h01)) : 8'h00;
  assign rdata   = inta ? {base, win} : (addr ? mask : isr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_UNINIT;
      irr <= '0; isr <= '0; mask <= 8'hFF; prev <= '0;
      base <= '0; ltim <= 1'b0; sngl <= 1'b0; ic4 <= 1'b0; cascade <= '0;
    end else begin
      prev <= irq_in;
      if (icw1) begin
        state <= S_W2;
        ltim <= wdata[3]; sngl <= wdata[1]; ic4 <= wdata[0];
        irr <= '0; isr <= '0; mask <= 8'hFF;
      end else begin
        if (ready)
          irr <= ltim ? irq_in : ((irr | (irq_in & ~prev)) & ~set_m);
        isr <= (isr & ~clr_m) | set_m;
        if (port1) begin
          case (state)
            S_W2: begin
              base  <= wdata[7:3];
              state <= !sngl ? S_W3 : (ic4 ? S_W4 : S_RDY);
            end
            S_W3: begin
              cascade <= wdata;
              state   <= ic4 ? S_W4 : S_RDY;
            end
            S_W4:    state <= S_RDY;
            S_RDY:   mask  <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  p_ack_adds_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !eoi && !icw1 |=> $countones(isr) == $past($countones(isr)) + 1);
  p_eoi_drops_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !ack && (isr != 8'h00) |=> $countones(isr) == $past($countones(isr)) - 1);
  p_icw1_clears_isr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    icw1 |=> (isr == 8'h00) && !int_req);
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));
endmodule

// File: tb/irq_ctrl8_test.sv
module irq_ctrl8_test;
  logic clk = 0, rst_n = 0, wr_en = 0, addr = 0, inta = 0;
  logic [7:0] wdata = 0, irq_in = 0, rdata;
  logic int_req;
  int n_chk = 0, n_fail = 0;
  logic [7:0] expq[$];

  irq_ctrl8 uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                 .rdata(rdata), .irq_in(irq_in), .int_req(int_req), .inta(inta));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic a, input logic [7:0] d);
    tick(); wr_en = 1; addr = a; wdata = d;
    tick(); wr_en = 0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string req);
    addr = a; #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic ack(input logic [7:0] v);
    expq.push_back(v);
    tick(); inta = 1;
    tick(); inta = 0;
  endtask

  always @(negedge clk) if (inta) begin
    if (expq.size() == 0) chk(0, "R8 unexpected ack", rdata, 0);
    else begin
      logic [7:0] e;
      e = expq.pop_front();
      chk(int_req && rdata == e, "R8 vector", rdata, e);
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R1
    chk(!int_req, "R1 int_req", int_req, 0);
    rd(1, 8'hFF, "R1 mask");
    rd(0, 8'h00, "R1 isr");
    // R2: no interrupt before setup completes
    irq_in = 8'h01; tick(); tick();
    chk(!int_req, "R2 before setup", int_req, 0);
    irq_in = 0;
    // R3: edge, cascade, with fourth word
    wr(0, 8'h11); wr(1, 8'h40);
    irq_in = 8'h01; tick(); tick();
    chk(!int_req, "R2 mid setup", int_req, 0);
    irq_in = 0;
    wr(1, 8'h00); wr(1, 8'h01);
    wr(1, 8'h00);
    rd(1, 8'h00, "R4 mask after setup");
    // R5 edge latch
    irq_in = 8'h08; tick(); tick();
    chk(int_req, "R5 edge raise", int_req, 1);
    ack(8'h43);
    rd(0, 8'h08, "R10 isr after ack");
    tick();
    chk(!int_req, "R5 held high no retrigger", int_req, 0);
    // R7 priority and nesting
    irq_in = 8'h2A; tick(); tick();
    chk(int_req, "R7 higher nests", int_req, 1);
    ack(8'h41);
    rd(0, 8'h0A, "R7 isr nested");
    tick();
    chk(!int_req, "R7 line5 blocked", int_req, 0);
    wr(0, 8'h20);
    rd(0, 8'h08, "R9 eoi clears line1");
    chk(!int_req, "R7 still blocked by 3", int_req, 0);
    wr(0, 8'h60);
    rd(0, 8'h08, "R9 sl write ignored");
    wr(0, 8'h20);
    rd(0, 8'h00, "R9 eoi clears line3");
    chk(int_req, "R7 line5 released", int_req, 1);
    ack(8'h45);
    wr(0, 8'h20);
    irq_in = 0; tick();
    // R4 mask
    wr(1, 8'h04);
    rd(1, 8'h04, "R4 readback");
    irq_in = 8'h04; tick(); tick();
    chk(!int_req, "R4 masked", int_req, 0);
    wr(1, 8'h00);
    chk(int_req, "R4 unmasked", int_req, 1);
    ack(8'h42);
    // R2 restart clears isr, sets mask; R6 level, single, no fourth word
    wr(0, 8'h1A);
    rd(0, 8'h00, "R2 isr cleared");
    rd(1, 8'hFF, "R2 mask set");
    wr(1, 8'h88);
    wr(1, 8'h00);
    rd(1, 8'h00, "R3 single no icw4 mask");
    irq_in = 8'h40; tick(); tick();
    chk(int_req, "R6 level raise", int_req, 1);
    ack(8'h8E);
    wr(0, 8'h20);
    tick();
    chk(int_req, "R6 level re-raise", int_req, 1);
    irq_in = 0; tick(); tick();
    chk(!int_req, "R6 level drop", int_req, 0);
    // R3 restart mid-sequence
    wr(0, 8'h11); wr(1, 8'h20);
    wr(0, 8'h13); wr(1, 8'h30); wr(1, 8'h01);
    wr(1, 8'h00);
    rd(1, 8'h00, "R3 restart mask");
    irq_in = 8'h80; tick(); tick();
    ack(8'h37);
    tick();
    chk(expq.size() == 0, "R8 all vectors seen", expq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule